// File: doc/BRIEF.md
# Dual Performance Event Counter

This block monitors processor performance with two 32-bit event counters. Every clock it samples a set of one-bit strobes from the pipeline and the caches: retired and squashed instructions, three stall conditions, and reference and hit strobes for the instruction cache, the data cache read path and the second-level cache. Each counter has its own 4-bit event select in a shared control register. A counter adds one in each clock where its selected event is active and the current privilege level is enabled for counting.

Software reaches the control register and both counters over a small register bus. Writes take effect at the clock edge and reads are combinational. A sticky flag per counter records a wrap from all-ones to zero. Software reads and clears the counters often enough to avoid losing counts, and it works out ratios such as cycles per instruction or hit rates from pairs of counts.

Top module: `perf_event_pair`

## Requirements
- R1: After reset the control register reads 0x0000_0110: counter 0 selects code 0, counter 1 selects code 1, the user enable is set, the supervisor enable is clear and both overflow flags are clear. Both counters read 0. The bus addresses are 0 for control, 1 for counter 0, 2 for counter 1, and address 3 reads 0.
- R2: `priv_sup` gives the privilege level (0 = user, 1 = supervisor). An event counts only if the enable bit for that level is set: control bit 8 for user, bit 9 for supervisor.
- R3: Select code 0 on either counter counts every clock in which counting is enabled.
- R4: Select code 1 on either counter counts the clocks where `ev_retire` is high and `ev_squash` is low.
- R5: Stall events count once per clock the condition holds. On counter 0, code 2 counts `ev_stall_ifetch` and code 3 counts `ev_stall_load`.
- R6: On counter 1, code 2 counts `ev_stall_fp` only in clocks where `ev_stall_load` is low.
- R7: Cache events are split between the counters. Counter 0 codes 4, 5 and 6 count `ic_ref`, `dc_rd_ref` and `l2_ref`. Counter 1 codes 4, 5 and 6 count `ic_hit`, `dc_rd_hit` and `l2_hit`.
- R8: Codes a counter does not support count nothing: codes 7 to 15 on counter 0, and codes 3 and 7 to 15 on counter 1.
- R9: A bus write to a counter loads exactly the written value, even if an increment occurs in the same clock.
- R10: Counters wrap modulo 2^32. On a wrap from all-ones to zero, control bit 16 (counter 0) or bit 17 (counter 1) is set and stays set until the control register is written. A wrap in the same clock as a control write leaves the flag set. A control write loads bits 3:0 into select 0, bits 7:4 into select 1, bit 8 into the user enable and bit 9 into the supervisor enable.
- R11: `bus_rdata` shows the addressed register in the same clock. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_sup | input | 1 | Current privilege level, 1 = supervisor |
| ev_retire | input | 1 | Instruction completed this clock |
| ev_squash | input | 1 | The completing instruction was annulled, mispredicted or trapped |
| ev_stall_ifetch | input | 1 | Instruction buffer empty after an instruction cache miss |
| ev_stall_load | input | 1 | Load-use dependency stall |
| ev_stall_fp | input | 1 | Floating-point result dependency stall |
| ic_ref | input | 1 | Instruction cache reference |
| ic_hit | input | 1 | Instruction cache hit |
| dc_rd_ref | input | 1 | Data cache read reference |
| dc_rd_hit | input | 1 | Data cache read hit |
| l2_ref | input | 1 | Second-level cache reference |
| l2_hit | input | 1 | Second-level cache hit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |

## Verification
The assertions check these rules on every clock: a counter write loads the written value, a counter never moves when the current privilege level is disabled or its select is unsupported, a counter steps by at most one, the floating-point stall is never counted while a load-use stall is active, and the overflow flags are sticky and set on a wrap. The bench scenarios cover the rules that depend on which event a code maps to: the cache reference and hit split between the counters, the stall counts per clock, the exclusion of squashed instructions, and the same-clock collision of a wrap with a control write. A random phase compares every readable register against a behavioural model on every clock.

// File: rtl/perf_event_pair.sv
`timescale 1ns/1ps
module perf_event_pair #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        priv_sup,
  input  logic        ev_retire,
  input  logic        ev_squash,
  input  logic        ev_stall_ifetch,
  input  logic        ev_stall_load,
  input  logic        ev_stall_fp,
  input  logic        ic_ref,
  input  logic        ic_hit,
  input  logic        dc_rd_ref,
  input  logic        dc_rd_hit,
  input  logic        l2_ref,
  input  logic        l2_hit,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int SEL_W = 4;
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT0 = 2'd1, A_CNT1 = 2'd2;

  logic [SEL_W-1:0] sel0, sel1;
  logic             user_en, sup_en, ovf0, ovf1;
  logic [CNT_W-1:0] cnt0, cnt1;
  logic             hit0, hit1;

  logic count_ok, insn_ok, fp_ok;
  logic wr_ctrl, wr_c0, wr_c1, inc0, inc1, wrap0, wrap1;

  assign count_ok = priv_sup ? sup_en : user_en;
  assign insn_ok  = ev_retire & ~ev_squash;
  assign fp_ok    = ev_stall_fp & ~ev_stall_load;

  always_comb begin
    case (sel0)
      4'd0:    hit0 = 1'b1;
      4'd1:    hit0 = insn_ok;
      4'd2:    hit0 = ev_stall_ifetch;
      4'd3:    hit0 = ev_stall_load;
      4'd4:    hit0 = ic_ref;
      4'd5:    hit0 = dc_rd_ref;
      4'd6:    hit0 = l2_ref;
      default: hit0 = 1'b0;
    endcase
    case (sel1)
      4'd0:    hit1 = 1'b1;
      4'd1:    hit1 = insn_ok;
      4'd2:    hit1 = fp_ok;
      4'd4:    hit1 = ic_hit;
      4'd5:    hit1 = dc_rd_hit;
      4'd6:    hit1 = l2_hit;
      default: hit1 = 1'b0;
    endcase
  end

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_c0   = bus_wr && (bus_addr == A_CNT0);
  assign wr_c1   = bus_wr && (bus_addr == A_CNT1);
  assign inc0    = count_ok & hit0;
  assign inc1    = count_ok & hit1;
  assign wrap0   = inc0 & ~wr_c0 & (&cnt0);
  assign wrap1   = inc1 & ~wr_c1 & (&cnt1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt0 <= '0;
      cnt1 <= '0;
    end else begin
      if (wr_c0)     cnt0 <= bus_wdata[CNT_W-1:0];
      else if (inc0) cnt0 <= cnt0 + 1'b1;
      if (wr_c1)     cnt1 <= bus_wdata[CNT_W-1:0];
      else if (inc1) cnt1 <= cnt1 + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel0    <= 4'd0;
      sel1    <= 4'd1;
      user_en <= 1'b1;
      sup_en  <= 1'b0;
      ovf0    <= 1'b0;
      ovf1    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel0    <= bus_wdata[3:0];
        sel1    <= bus_wdata[7:4];
        user_en <= bus_wdata[8];
        sup_en  <= bus_wdata[9];
      end
      ovf0 <= wrap0 | (ovf0 & ~wr_ctrl);
      ovf1 <= wrap1 | (ovf1 & ~wr_ctrl);
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {14'd0, ovf1, ovf0, 6'd0, sup_en, user_en, sel1, sel0};
      A_CNT0:  bus_rdata = 32'(cnt0);
      A_CNT1:  bus_rdata = 32'(cnt1);
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

module perf_event_pair_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             priv_sup,
  input logic             ev_stall_load,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [3:0]       sel0,
  input logic [3:0]       sel1,
  input logic             user_en,
  input logic             sup_en,
  input logic             ovf0,
  input logic             ovf1,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1
);
  logic w0, w1, wc, lvl_on;
  assign w0 = bus_wr && bus_addr == 2'd1;
  assign w1 = bus_wr && bus_addr == 2'd2;
  assign wc = bus_wr && bus_addr == 2'd0;
  assign lvl_on = priv_sup ? sup_en : user_en;

  assert_write_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    w0 |=> cnt0 == $past(bus_wdata[CNT_W-1:0]));
  assert_write_load1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    w1 |=> cnt1 == $past(bus_wdata[CNT_W-1:0]));
  assert_priv_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl_on && !w0 && !w1) |=> ($stable(cnt0) && $stable(cnt1)));
  assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !w0 |=> (cnt0 == $past(cnt0) || cnt0 == CNT_W'($past(cnt0) + 1'b1)));
  assert_unsupported_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 > 4'd6 && !w0) |=> $stable(cnt0));
  assert_unsupported1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel1 > 4'd6 || sel1 == 4'd3) && !w1) |=> $stable(cnt1));
  assert_fp_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel1 == 4'd2 && ev_stall_load && !w1) |=> $stable(cnt1));
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf0 && !wc) |=> ovf0);
  assert_sticky1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf1 && !wc) |=> ovf1);
  assert_wrap_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!w0 && (&cnt0)) |=> (cnt0 != '0 || ovf0));
endmodule

bind perf_event_pair perf_event_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv_sup(priv_sup), .ev_stall_load(ev_stall_load),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .sel0(sel0), .sel1(sel1), .user_en(user_en), .sup_en(sup_en),
  .ovf0(ovf0), .ovf1(ovf1), .cnt0(cnt0), .cnt1(cnt1)
);

// File: tb/perf_event_pair_bench.sv
`timescale 1ns/1ps
module perf_event_pair_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic priv_sup = 1'b0;
  logic ev_retire = 1'b0, ev_squash = 1'b0, ev_stall_ifetch = 1'b0, ev_stall_load = 1'b0, ev_stall_fp = 1'b0;
  logic ic_ref = 1'b0, ic_hit = 1'b0, dc_rd_ref = 1'b0, dc_rd_hit = 1'b0, l2_ref = 1'b0, l2_hit = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;

  always #10 clk = ~clk;

  perf_event_pair u_perf_event_pair (
    .clk(clk), .rst_n(rst_n), .priv_sup(priv_sup),
    .ev_retire(ev_retire), .ev_squash(ev_squash), .ev_stall_ifetch(ev_stall_ifetch),
    .ev_stall_load(ev_stall_load), .ev_stall_fp(ev_stall_fp),
    .ic_ref(ic_ref), .ic_hit(ic_hit), .dc_rd_ref(dc_rd_ref), .dc_rd_hit(dc_rd_hit),
    .l2_ref(l2_ref), .l2_hit(l2_hit),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [1:0] rd_rot = 2'd0;

  logic [31:0] m_c0 = 0, m_c1 = 0;
  logic [3:0]  m_sel0 = 4'd0, m_sel1 = 4'd1;
  logic        m_user = 1'b1, m_sup = 1'b0, m_ovf0 = 1'b0, m_ovf1 = 1'b0;

  function automatic logic [31:0] mread(input logic [1:0] a);
    case (a)
      2'd0: return (32'(m_ovf1) << 17) | (32'(m_ovf0) << 16) | (32'(m_sup) << 9) |
                   (32'(m_user) << 8) | (32'(m_sel1) << 4) | 32'(m_sel0);
      2'd1: return m_c0;
      2'd2: return m_c1;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit fires0(input logic [3:0] s);
    case (s)
      4'd0: return 1;
      4'd1: return ev_retire && !ev_squash;
      4'd2: return ev_stall_ifetch;
      4'd3: return ev_stall_load;
      4'd4: return ic_ref;
      4'd5: return dc_rd_ref;
      4'd6: return l2_ref;
      default: return 0;
    endcase
  endfunction

  function automatic bit fires1(input logic [3:0] s);
    case (s)
      4'd0: return 1;
      4'd1: return ev_retire && !ev_squash;
      4'd2: return ev_stall_fp && !ev_stall_load;
      4'd4: return ic_hit;
      4'd5: return dc_rd_hit;
      4'd6: return l2_hit;
      default: return 0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    bit ok, e0, e1, w0, w1, wc, wrap0, wrap1;
    if (!bus_wr) begin bus_addr = rd_rot; rd_rot = rd_rot + 2'd1; end
    #1;
    check(bus_rdata, mread(bus_addr), tag);
    ok = priv_sup ? m_sup : m_user;
    e0 = ok && fires0(m_sel0);
    e1 = ok && fires1(m_sel1);
    w0 = bus_wr && bus_addr == 2'd1;
    w1 = bus_wr && bus_addr == 2'd2;
    wc = bus_wr && bus_addr == 2'd0;
    wrap0 = e0 && !w0 && m_c0 == 32'hFFFF_FFFF;
    wrap1 = e1 && !w1 && m_c1 == 32'hFFFF_FFFF;
    if (w0) m_c0 = bus_wdata; else if (e0) m_c0 = m_c0 + 1;
    if (w1) m_c1 = bus_wdata; else if (e1) m_c1 = m_c1 + 1;
    if (wc) begin
      m_sel0 = bus_wdata[3:0]; m_sel1 = bus_wdata[7:4];
      m_user = bus_wdata[8];   m_sup  = bus_wdata[9];
      m_ovf0 = wrap0;          m_ovf1 = wrap1;
    end else begin
      m_ovf0 = m_ovf0 | wrap0; m_ovf1 = m_ovf1 | wrap1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step(tag);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_wr = 1'b0; bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [31:0] exp, input string tag);
    bus_wr = 1'b0; bus_addr = a; #1;
    check(bus_rdata, exp, tag);
  endtask

  task automatic quiet();
    {ev_retire, ev_squash, ev_stall_ifetch, ev_stall_load, ev_stall_fp} = '0;
    {ic_ref, ic_hit, dc_rd_ref, dc_rd_hit, l2_ref, l2_hit} = '0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11 actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] b0, b1;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and map
    expect_reg(2'd0, 32'h0000_0110, "R1 ctrl reset");
    expect_reg(2'd1, 32'd0, "R1 cnt0 reset");
    expect_reg(2'd2, 32'd0, "R1 cnt1 reset");
    expect_reg(2'd3, 32'd0, "R1 unmapped read");

    // R3 cycles, R4 retired minus squashed
    rd(2'd1, b0); rd(2'd2, b1); n = 0;
    for (int i = 0; i < 10; i++) begin
      ev_retire = (i % 3 != 0); ev_squash = (i % 5 == 0);
      if (ev_retire && !ev_squash) n++;
      step("R3 R4 run");
    end
    quiet();
    expect_reg(2'd1, b0 + 10, "R3 cycle count");
    expect_reg(2'd2, b1 + 32'(n), "R4 instruction count");

    // R2 privilege gating
    priv_sup = 1'b1; rd(2'd1, b0);
    repeat (6) step("R2 sup disabled");
    expect_reg(2'd1, b0, "R2 sup disabled hold");
    wr(2'd0, 32'h0000_0310, "R2 enable sup");
    rd(2'd1, b0);
    repeat (6) step("R2 sup enabled");
    expect_reg(2'd1, b0 + 6, "R2 sup counted");
    wr(2'd0, 32'h0000_0200, "R2 user off");
    priv_sup = 1'b0; rd(2'd1, b0); rd(2'd2, b1);
    repeat (5) step("R2 user disabled");
    expect_reg(2'd1, b0, "R2 user off cnt0");
    expect_reg(2'd2, b1, "R2 user off cnt1");

    // R5 stall per clock, R8 code 3 on counter 1
    wr(2'd0, 32'h0000_0132, "R5 select ifetch stall");
    rd(2'd1, b0); rd(2'd2, b1);
    for (int i = 0; i < 8; i++) begin
      ev_stall_ifetch = (i < 5); ev_stall_load = 1'b1;
      step("R5 ifetch stall");
    end
    quiet();
    expect_reg(2'd1, b0 + 5, "R5 ifetch stall clocks");
    expect_reg(2'd2, b1, "R8 code3 on cnt1 idle");

    // R6 fp stall exclusive of load stall; R5 load stall on counter 0
    wr(2'd0, 32'h0000_0123, "R6 select");
    rd(2'd1, b0); rd(2'd2, b1);
    for (int i = 0; i < 8; i++) begin
      ev_stall_fp = 1'b1; ev_stall_load = (i < 3);
      step("R6 fp stall");
    end
    quiet();
    expect_reg(2'd1, b0 + 3, "R5 load stall clocks");
    expect_reg(2'd2, b1 + 5, "R6 fp stall excluded");

    // R7 cache reference/hit split
    for (int k = 4; k <= 6; k++) begin
      wr(2'd0, 32'h100 | 32'(k << 4) | 32'(k), "R7 select cache");
      rd(2'd1, b0); rd(2'd2, b1);
      repeat (4) begin
        ic_ref = (k == 4); dc_rd_ref = (k == 5); l2_ref = (k == 6);
        step("R7 refs");
      end
      quiet();
      repeat (2) begin
        ic_hit = (k == 4); dc_rd_hit = (k == 5); l2_hit = (k == 6);
        step("R7 hits");
      end
      quiet();
      expect_reg(2'd1, b0 + 4, "R7 refs on cnt0 only");
      expect_reg(2'd2, b1 + 2, "R7 hits on cnt1 only");
    end

    // R8 unsupported codes with every strobe high
    wr(2'd0, 32'h0000_01F7, "R8 select unsupported");
    rd(2'd1, b0); rd(2'd2, b1);
    {ev_retire, ev_stall_ifetch, ev_stall_load, ev_stall_fp} = '1;
    {ic_ref, ic_hit, dc_rd_ref, dc_rd_hit, l2_ref, l2_hit} = '1;
    repeat (5) step("R8 unsupported");
    quiet();
    expect_reg(2'd1, b0, "R8 cnt0 code7");
    expect_reg(2'd2, b1, "R8 cnt1 code15");

    // R9 write wins over increment
    wr(2'd0, 32'h0000_0110, "R9 cycles");
    wr(2'd1, 32'h0000_1234, "R9 write cnt0");
    expect_reg(2'd1, 32'h0000_1234, "R9 written value");

    // R10 wrap and sticky overflow
    wr(2'd1, 32'hFFFF_FFFE, "R10 near wrap");
    step("R10 count");
    expect_reg(2'd1, 32'hFFFF_FFFF, "R10 all ones");
    step("R10 wrap");
    expect_reg(2'd1, 32'd0, "R10 wrapped");
    expect_reg(2'd0, 32'h0001_0110, "R10 ovf0 set");
    repeat (3) step("R10 sticky");
    expect_reg(2'd0, 32'h0001_0110, "R10 ovf0 sticky");
    wr(2'd0, 32'h0000_0110, "R10 clear");
    expect_reg(2'd0, 32'h0000_0110, "R10 ovf0 cleared");
    wr(2'd1, 32'hFFFF_FFFF, "R10 arm");
    wr(2'd0, 32'h0000_0110, "R10 collide");
    expect_reg(2'd0, 32'h0001_0110, "R10 wrap beats clear");
    wr(2'd0, 32'h0000_0100, "R10 cnt1 cycles");
    wr(2'd2, 32'hFFFF_FFFF, "R10 arm cnt1");
    step("R10 wrap cnt1");
    expect_reg(2'd0, 32'h0002_0100, "R10 ovf1 set");

    // R11 address 3 write ignored
    rd(2'd1, b0); rd(2'd2, b1);
    wr(2'd3, 32'hDEAD_BEEF, "R11 write addr3");
    expect_reg(2'd0, 32'h0002_0100, "R11 ctrl untouched");
    expect_reg(2'd1, b0 + 1, "R11 cnt0 untouched");
    expect_reg(2'd3, 32'd0, "R11 addr3 still zero");

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      {ev_retire, ev_squash, ev_stall_ifetch, ev_stall_load, ev_stall_fp} = r[4:0];
      {ic_ref, ic_hit, dc_rd_ref, dc_rd_hit, l2_ref, l2_hit} = r[10:5];
      priv_sup = r[11];
      if (r[15:13] == 3'd0) begin
        bus_wr = 1'b1; bus_addr = r[17:16];
        bus_wdata = r[18] ? (32'hFFFF_FFF0 | 32'(r[22:19])) : $urandom;
        step("R11 random write");
        bus_wr = 1'b0;
      end else begin
        step("R11 random run");
      end
    end
    quiet();

    done = 1;
    summary();
    $finish;
  end
endmodule